// File: doc/BRIEF.md
# Four-Slot Edge Timestamp Capture

This block records the times at which edges occur on a single asynchronous input pin. A free-running counter serves as the time base. Each qualifying edge stores the current time into one of four capture slots. A two-bit rotating index picks the slot, so a run of edges fills slots 0, 1, 2 and 3 in turn and then wraps back to 0. Each slot has its own edge sense, rising or falling. Software can therefore measure a whole waveform in one pass, for example a period and a duty cycle, without reprogramming between edges.

The block has two run modes. In continuous mode the index keeps wrapping. In one-shot mode capture halts after a programmed number of captures, from one to four, until a re-arm pulse restarts it. Every capture produces a one-cycle strobe that carries the slot number. Each slot has a sticky capture flag and an overrun flag. A global interrupt flag, with per-slot enables, stays raised until it is cleared. A single-cycle interrupt pulse marks each rise of that flag.

Top module: `ets_capture`

## Requirements
- R1: The time base increments by one on every clock and wraps from all-ones to zero. When `ctr_clr` is high at a clock edge, the time base loads zero instead.
- R2: The pin passes through two synchronizer flops. A capture is written on the second clock edge after the edge that first samples the new level. The stored value is the time base count in the capture cycle minus one. A slot that receives no capture keeps its value.
- R3: Captures fill the slots in the order 0, 1, 2, 3, 0. `next_slot` shows the slot that the next capture will use. An edge that does not qualify for that slot is ignored and leaves the index unchanged.
- R4: Bit i of `edge_pol` sets the edge sense of slot i. A value of 1 selects falling edges and 0 selects rising edges.
- R5: When `oneshot_en` is 1, the capture into slot `stop_sel` (encoding 0..3, meaning halt after 1..4 captures) returns the index to 0 and drops `armed`. Qualifying edges are then ignored while `armed` is 0. When `oneshot_en` is 0, capture ignores `armed` and the index always wraps 3 to 0.
- R6: A `rearm` pulse sets the index to 0 and `armed` to 1. An edge that qualifies in the same cycle is discarded.
- R7: A capture into slot i sets `slot_flag[i]`, which stays set until `flag_clr[i]`. If a capture and a clear happen in the same cycle, the flag ends up set.
- R8: A capture into a slot whose flag is set, with no clear of that slot in the same cycle, sets `ovf_flag[i]`. The register is still overwritten. `flag_clr[i]` also clears `ovf_flag[i]`.
- R9: A capture into a slot whose `irq_en` bit is 1 raises `irq`. `irq` then stays high until `gint_clr` is applied. If a set and a clear happen in the same cycle, `irq` stays high.
- R10: `irq_pulse` is high for one cycle only when `irq` goes from 0 to 1. Further captures while `irq` is high produce no pulse.
- R11: `cap_stb` is high for the one cycle in which a new capture value first appears. `last_slot` holds the slot of the most recent capture.
- R12: Reset is synchronous and active high. After reset the time base and all slots read zero, all flags and `irq` are low, the index is 0 and `armed` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | 1 | Asynchronous signal whose edges are timed |
| ctr_clr | input | 1 | Synchronous clear of the time base |
| edge_pol | input | 4 | Per-slot edge sense, 1 = falling |
| oneshot_en | input | 1 | 1 = one-shot mode, 0 = continuous |
| stop_sel | input | 2 | Last slot of a one-shot pass |
| rearm | input | 1 | Restart pulse for one-shot mode |
| irq_en | input | 4 | Per-slot interrupt enable |
| flag_clr | input | 4 | Per-slot clear of capture and overrun flags |
| gint_clr | input | 1 | Clear of the global interrupt flag |
| cap_ts | output | 4x32 | Captured timestamps, slot i at bits [32i+31:32i] |
| cap_stb | output | 1 | New capture present this cycle |
| last_slot | output | 2 | Slot of the most recent capture |
| next_slot | output | 2 | Slot the next capture will use |
| armed | output | 1 | One-shot capture enabled |
| slot_flag | output | 4 | Sticky per-slot capture flags |
| ovf_flag | output | 4 | Sticky per-slot overrun flags |
| irq | output | 1 | Global interrupt flag |
| irq_pulse | output | 1 | One-cycle marker of each rise of `irq` |

## Verification
A wrong index shows up on the very next capture, as a timestamp landing in the wrong slot and a wrong `last_slot`. `next_slot` exposes it even earlier, in the cycle right after the fault. A fault in the synchronizer depth or the latency adjustment shifts every stored timestamp by a constant. That offset is visible on the first capture after reset. Faults in flag or interrupt state appear on the flag outputs within one cycle of the capture or clear that should have changed them. A wrong one-shot halt shows up either as a capture strobe that should not occur or as a strobe missing at the next qualifying edge.

// File: rtl/ets_pkg.sv
package ets_pkg;
    localparam int SLOTS = 4;
    localparam int IDX_W = $clog2(SLOTS);

    typedef logic [IDX_W-1:0] slot_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    typedef struct packed {
        logic  hit;
        slot_t slot;
    } cap_evt_t;

    function automatic logic edge_matches(edge_t e, logic fall_sel);
        return fall_sel ? e.fall : e.rise;
    endfunction

    function automatic slot_t slot_after(slot_t s);
        return s + 1'b1;
    endfunction
endpackage

// File: rtl/ets_sync_edge.sv
module ets_sync_edge
    import ets_pkg::*;
#(
    parameter int STAGES = 2
)(
    input  logic  clk,
    input  logic  rst,
    input  logic  din,
    output edge_t edg
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    always_comb begin
        edg.rise = chain[STAGES-1] & ~prev;
        edg.fall = ~chain[STAGES-1] & prev;
    end
endmodule

// File: rtl/ets_timebase.sv
module ets_timebase #(
    parameter int W = 32
)(
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr) count <= '0;
        else            count <= count + 1'b1;
    end
endmodule

// File: rtl/ets_sequencer.sv
module ets_sequencer
    import ets_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  edge_t            edg,
    input  logic [SLOTS-1:0] pol,
    input  logic             oneshot,
    input  slot_t            stop_sel,
    input  logic             rearm,
    output slot_t            idx,
    output logic             armed,
    output cap_evt_t         evt
);
    logic allow;

    always_comb begin
        allow    = !rearm && (!oneshot || armed);
        evt.hit  = allow && edge_matches(edg, pol[idx]);
        evt.slot = idx;
    end

    always_ff @(posedge clk) begin
        if (rst || rearm) begin
            idx   <= '0;
            armed <= 1'b1;
        end else if (evt.hit) begin
            if (oneshot && idx == stop_sel) begin
                idx   <= '0;
                armed <= 1'b0;
            end else begin
                idx <= slot_after(idx);
            end
        end
    end
endmodule

// File: rtl/ets_slot.sv
module ets_slot #(
    parameter int W = 32
)(
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] ts,
    input  logic         clr,
    output logic [W-1:0] val,
    output logic         flag,
    output logic         ovf
);
    always_ff @(posedge clk) begin
        if (rst) begin
            val  <= '0;
            flag <= 1'b0;
            ovf  <= 1'b0;
        end else begin
            if (wr) val <= ts;
            flag <= wr | (flag & ~clr);
            ovf  <= (wr & flag & ~clr) | (ovf & ~clr);
        end
    end
endmodule

// File: rtl/ets_capture.sv
module ets_capture
    import ets_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
)(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        pin_in,
    input  logic                        ctr_clr,
    input  logic [SLOTS-1:0]            edge_pol,
    input  logic                        oneshot_en,
    input  logic [IDX_W-1:0]            stop_sel,
    input  logic                        rearm,
    input  logic [SLOTS-1:0]            irq_en,
    input  logic [SLOTS-1:0]            flag_clr,
    input  logic                        gint_clr,
    output logic [SLOTS-1:0][CNT_W-1:0] cap_ts,
    output logic                        cap_stb,
    output logic [IDX_W-1:0]            last_slot,
    output logic [IDX_W-1:0]            next_slot,
    output logic                        armed,
    output logic [SLOTS-1:0]            slot_flag,
    output logic [SLOTS-1:0]            ovf_flag,
    output logic                        irq,
    output logic                        irq_pulse
);
    localparam int               TS_ADJ   = SYNC_STAGES - 1;
    localparam logic [CNT_W-1:0] TS_ADJ_V = CNT_W'(TS_ADJ);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ts_now;
    edge_t            edg;
    cap_evt_t         evt;
    slot_t            idx;
    logic             set_irq;

    ets_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (pin_in),
        .edg (edg)
    );

    ets_timebase #(.W(CNT_W)) u_time (
        .clk   (clk),
        .rst   (rst),
        .clr   (ctr_clr),
        .count (cnt_q)
    );

    ets_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .edg      (edg),
        .pol      (edge_pol),
        .oneshot  (oneshot_en),
        .stop_sel (stop_sel),
        .rearm    (rearm),
        .idx      (idx),
        .armed    (armed),
        .evt      (evt)
    );

    assign ts_now    = cnt_q - TS_ADJ_V;
    assign next_slot = idx;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        ets_slot #(.W(CNT_W)) u_slot (
            .clk  (clk),
            .rst  (rst),
            .wr   (evt.hit && evt.slot == slot_t'(i)),
            .ts   (ts_now),
            .clr  (flag_clr[i]),
            .val  (cap_ts[i]),
            .flag (slot_flag[i]),
            .ovf  (ovf_flag[i])
        );
    end

    assign set_irq = evt.hit && irq_en[evt.slot];

    always_ff @(posedge clk) begin
        if (rst) begin
            irq       <= 1'b0;
            irq_pulse <= 1'b0;
            cap_stb   <= 1'b0;
            last_slot <= '0;
        end else begin
            irq       <= set_irq | (irq & ~gint_clr);
            irq_pulse <= set_irq & ~irq;
            cap_stb   <= evt.hit;
            if (evt.hit) last_slot <= evt.slot;
        end
    end
endmodule

// File: rtl/ets_capture_chk.sv
module ets_capture_chk
    import ets_pkg::*;
#(
    parameter int CNT_W = 32
)(
    input logic                        clk,
    input logic                        rst,
    input logic                        ctr_clr,
    input logic                        oneshot_en,
    input logic                        rearm,
    input logic [SLOTS-1:0]            flag_clr,
    input logic                        gint_clr,
    input logic [SLOTS-1:0][CNT_W-1:0] cap_ts,
    input logic                        cap_stb,
    input logic [IDX_W-1:0]            last_slot,
    input logic [IDX_W-1:0]            next_slot,
    input logic                        armed,
    input logic [SLOTS-1:0]            slot_flag,
    input logic [SLOTS-1:0]            ovf_flag,
    input logic                        irq,
    input logic                        irq_pulse,
    input logic [CNT_W-1:0]            cnt_q
);
    p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ctr_clr)) |-> cnt_q == $past(cnt_q) + 1'b1);

    p_count_clear_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ctr_clr)) |-> cnt_q == '0);

    p_hold_slots_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !cap_stb) |-> $stable(cap_ts));

    p_slot_order_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && cap_stb) |-> last_slot == $past(next_slot));

    p_halted_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(oneshot_en && !armed && !rearm)) |-> !cap_stb);

    p_flag_on_capture_r7: assert property (@(posedge clk) disable iff (rst)
        cap_stb |-> slot_flag[last_slot]);

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(flag_clr) == '0) |-> (ovf_flag & $past(ovf_flag)) == $past(ovf_flag));

    p_irq_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(irq && !gint_clr)) |-> irq);

    p_pulse_on_rise_r10: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> (irq && !$past(irq)));
endmodule

bind ets_capture ets_capture_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctr_clr    (ctr_clr),
    .oneshot_en (oneshot_en),
    .rearm      (rearm),
    .flag_clr   (flag_clr),
    .gint_clr   (gint_clr),
    .cap_ts     (cap_ts),
    .cap_stb    (cap_stb),
    .last_slot  (last_slot),
    .next_slot  (next_slot),
    .armed      (armed),
    .slot_flag  (slot_flag),
    .ovf_flag   (ovf_flag),
    .irq        (irq),
    .irq_pulse  (irq_pulse),
    .cnt_q      (cnt_q)
);

// File: tb/tb_ets_capture.sv
`timescale 1ns/1ps
module tb_ets_capture;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              pin_in = 1'b0;
    logic              ctr_clr = 1'b0;
    logic [3:0]        edge_pol = 4'h0;
    logic              oneshot_en = 1'b0;
    logic [1:0]        stop_sel = 2'd3;
    logic              rearm = 1'b0;
    logic [3:0]        irq_en = 4'h0;
    logic [3:0]        flag_clr = 4'h0;
    logic              gint_clr = 1'b0;
    logic [3:0][31:0]  cap_ts;
    logic              cap_stb;
    logic [1:0]        last_slot;
    logic [1:0]        next_slot;
    logic              armed;
    logic [3:0]        slot_flag;
    logic [3:0]        ovf_flag;
    logic              irq;
    logic              irq_pulse;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    bit live   = 0;

    always #2.5 clk = ~clk;

    ets_capture dut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .ctr_clr(ctr_clr),
        .edge_pol(edge_pol), .oneshot_en(oneshot_en), .stop_sel(stop_sel),
        .rearm(rearm), .irq_en(irq_en), .flag_clr(flag_clr), .gint_clr(gint_clr),
        .cap_ts(cap_ts), .cap_stb(cap_stb), .last_slot(last_slot),
        .next_slot(next_slot), .armed(armed), .slot_flag(slot_flag),
        .ovf_flag(ovf_flag), .irq(irq), .irq_pulse(irq_pulse)
    );

    // behavioural reference model
    logic [31:0] m_cnt;
    logic [31:0] m_ts [4];
    int          m_idx;
    bit          m_armed, m_gint, m_pulse, m_stb;
    int          m_last;
    bit [3:0]    m_flag, m_ovf;
    bit          pin_hist [$];

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_idx = 0; m_armed = 1; m_gint = 0; m_pulse = 0;
            m_stb = 0; m_last = 0; m_flag = 0; m_ovf = 0;
            foreach (m_ts[i]) m_ts[i] = 0;
            pin_hist = '{0, 0, 0};
        end else begin
            bit rise_e, fall_e, qual, cap, irq_set;
            int s;
            rise_e = pin_hist[1] && !pin_hist[2];
            fall_e = !pin_hist[1] && pin_hist[2];
            s = m_idx;
            cap = 0;
            if (rearm) begin
                m_idx = 0; m_armed = 1;
            end else begin
                qual = edge_pol[s] ? fall_e : rise_e;
                if (qual && (!oneshot_en || m_armed)) begin
                    cap = 1;
                    if (oneshot_en && s == int'(stop_sel)) begin
                        m_idx = 0; m_armed = 0;
                    end else begin
                        m_idx = (s + 1) % 4;
                    end
                end
            end
            for (int i = 0; i < 4; i++) begin
                bit hit;
                hit = cap && (s == i);
                m_ovf[i]  = (hit && m_flag[i] && !flag_clr[i]) || (m_ovf[i] && !flag_clr[i]);
                m_flag[i] = hit || (m_flag[i] && !flag_clr[i]);
                if (hit) m_ts[i] = m_cnt - 32'd1;
            end
            irq_set = cap && irq_en[s];
            m_pulse = irq_set && !m_gint;
            m_gint  = irq_set || (m_gint && !gint_clr);
            m_stb   = cap;
            if (cap) m_last = s;
            m_cnt = ctr_clr ? 32'd0 : m_cnt + 32'd1;
            pin_hist.push_front(pin_in);
            pin_hist = pin_hist[0:2];
        end
        live = 1;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (live && !done) begin
            for (int i = 0; i < 4; i++)
                chk("R1,R2", $sformatf("cap_ts[%0d]", i), cap_ts[i], m_ts[i]);
            chk("R3,R4,R6", "next_slot", 32'(next_slot), 32'(m_idx));
            chk("R5,R6", "armed", 32'(armed), 32'(m_armed));
            chk("R7", "slot_flag", 32'(slot_flag), 32'(m_flag));
            chk("R8", "ovf_flag", 32'(ovf_flag), 32'(m_ovf));
            chk("R9", "irq", 32'(irq), 32'(m_gint));
            chk("R10", "irq_pulse", 32'(irq_pulse), 32'(m_pulse));
            chk("R11", "cap_stb", 32'(cap_stb), 32'(m_stb));
            chk("R11", "last_slot", 32'(last_slot), 32'(m_last));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int hi, input int lo);
        pin_in = 1'b1; step(hi);
        pin_in = 1'b0; step(lo);
    endtask

    task automatic clear_all();
        flag_clr = 4'hF; gint_clr = 1'b1; step(1);
        flag_clr = 4'h0; gint_clr = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [1:0] sl;
        step(4);
        // R12: values held under reset
        chk("R12", "reset next_slot", 32'(next_slot), 0);
        chk("R12", "reset armed", 32'(armed), 1);
        chk("R12", "reset flags", 32'({slot_flag, ovf_flag, irq, irq_pulse, cap_stb}), 0);
        chk("R12", "reset cap_ts[2]", cap_ts[2], 0);
        rst = 1'b0;
        step(3);

        // continuous, rising on all slots, flags cleared between pulses
        irq_en = 4'hF;
        for (int k = 0; k < 6; k++) begin
            pulse(3, 4);
            clear_all();
        end

        // R4: mixed edge sense
        edge_pol = 4'b1010;
        for (int k = 0; k < 6; k++) begin
            pulse(2 + k, 3);
            flag_clr = 4'hF; step(1); flag_clr = 4'h0;
        end

        // R8: overrun when flags are left set; R9/R10 with partial enables
        edge_pol = 4'h0; irq_en = 4'b0100;
        clear_all();
        for (int k = 0; k < 9; k++) pulse(2, 2);
        clear_all();

        // R1/R2: exact latency and value after time-base clear
        step(6);
        ctr_clr = 1'b1; step(1); ctr_clr = 1'b0;
        step(5);
        sl = next_slot;
        pin_in = 1'b1;
        step(2);
        chk("R2", "cap_stb before latency", 32'(cap_stb), 0);
        step(1);
        chk("R2,R11", "cap_stb at latency", 32'(cap_stb), 1);
        step(1);
        chk("R1", "timestamp after clear", cap_ts[sl], 6);
        pin_in = 1'b0; step(4);

        // R5: one-shot stops after two captures
        rearm = 1'b1; oneshot_en = 1'b1; stop_sel = 2'd1; step(1); rearm = 1'b0;
        for (int k = 0; k < 5; k++) pulse(2, 3);
        chk("R5", "halted armed", 32'(armed), 0);
        chk("R5", "halted index", 32'(next_slot), 0);

        // R6: re-arm, then collide re-arm with a qualifying edge
        rearm = 1'b1; step(1); rearm = 1'b0;
        pin_in = 1'b1; step(2);
        rearm = 1'b1; step(1); rearm = 1'b0;
        chk("R6", "edge dropped on re-arm", 32'(cap_stb), 0);
        pin_in = 1'b0; step(3);

        // one-shot over all four slots, then continuous wrap
        stop_sel = 2'd3; edge_pol = 4'b0110;
        rearm = 1'b1; step(1); rearm = 1'b0;
        for (int k = 0; k < 6; k++) pulse(3, 3);
        oneshot_en = 1'b0;
        for (int k = 0; k < 5; k++) pulse(1, 1);

        // randomised phase
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            if ($urandom % 5 == 0) pin_in = ~pin_in;
            flag_clr = ($urandom % 6 == 0) ? 4'($urandom) : 4'h0;
            gint_clr = ($urandom % 9 == 0);
            rearm    = ($urandom % 45 == 0);
            ctr_clr  = ($urandom % 400 == 0);
            if ($urandom % 250 == 0) edge_pol = 4'($urandom);
            if ($urandom % 300 == 0) irq_en = 4'($urandom);
            if ($urandom % 350 == 0) oneshot_en = ~oneshot_en;
            if ($urandom % 200 == 0) stop_sel = 2'($urandom);
        end
        rearm = 1'b0; flag_clr = 4'h0; gint_clr = 1'b0; ctr_clr = 1'b0;
        step(5);

        done = 1;
        summary();
        $finish;
    end
endmodule